// File: doc/BRIEF.md
# Flagged Integer ALU

This block is a 32-bit integer arithmetic and logic unit with registered outputs. Each cycle it takes two operands and a 3-bit function code. One cycle later it presents the result together with three status flags: zero, carry-out and signed overflow.

All eight codes share a single operand conditioner and a single adder. The top bit of the code picks the inverted second operand and forces the adder's carry-in to 1, which turns addition into subtraction. The low two bits pick one of four result sources:

- bitwise AND;
- bitwise OR;
- the adder sum;
- a one-bit "less than" result taken from the sign of the sum.

Code 011 has no operation assigned. It returns zero.

The unit is meant to sit in an execute stage, where its one-cycle latency lines up with the pipeline register that follows it.

Top module: `alu_flagged_core`

## Requirements
- R1: A synchronous active-high reset drives the result to 0, the zero flag to 1, and the carry and overflow flags to 0.
- R2: Every output reflects the operands and code that were present at the previous rising clock edge. The latency is exactly one cycle.
- R3: Codes 000, 001, 100 and 101 give A AND B, A OR B, A AND NOT B and A OR NOT B respectively.
- R4: Code 010 gives A + B, modulo 2^32.
- R5: Code 110 gives A - B, computed as A + NOT B + 1, modulo 2^32.
- R6: Code 111 gives 1 when bit 31 of A - B is set and 0 otherwise. No correction is made for overflow, so A = 0x80000000 with B = 1 gives 0, and A = 25 with B = 32 gives 1.
- R7: Code 011 gives a result of 0 with the carry and overflow flags cleared.
- R8: The zero flag is 1 exactly when the 32-bit result is all zeros, for every code.
- R9: The carry flag is the adder's carry out of bit 31 for codes 010 and 110, and 0 for all other codes.
- R10: For codes 010 and 110, the overflow flag is 1 when both adder inputs, after the optional inversion of B, have the same sign and the sum's sign differs from it. For all other codes the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH (32) | First operand |
| b_in | input | WIDTH (32) | Second operand |
| func_sel | input | 3 | Function code; bit 2 inverts B and sets the carry-in, bits 1:0 select the result |
| y_out | output | WIDTH (32) | Registered result |
| zero_flag | output | 1 | Registered result-is-zero flag |
| carry_flag | output | 1 | Registered adder carry-out, add and subtract only |
| ovf_flag | output | 1 | Registered signed overflow, add and subtract only |

## Verification
The properties compare each registered output with the operands and code seen one edge earlier. They therefore assume that `a_in`, `b_in` and `func_sel` hold known values on every edge outside reset. They also assume that reset is released only after at least one edge at which the inputs were driven.

The stimulus drives all three inputs from time zero, including while reset is held. It changes the inputs only at falling edges, so every sampled value is a defined operand and code. The stimulus combines directed sign, carry and equality corner cases with random operands spread across all eight codes.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [1:0] {
    RES_AND  = 2'b00,
    RES_OR   = 2'b01,
    RES_SUM  = 2'b10,
    RES_SIGN = 2'b11
  } res_sel_e;

  localparam logic [2:0] FN_ADD    = 3'b010;
  localparam logic [2:0] FN_SUB    = 3'b110;
  localparam logic [2:0] FN_UNUSED = 3'b011;
  localparam logic [2:0] FN_LESS   = 3'b111;

endpackage

// File: rtl/alu_b_cond.sv
module alu_b_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             invert,
  output logic [WIDTH-1:0] b_eff
);
  assign b_eff = invert ? ~b_in : b_in;
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
      end
      assign cout = cy[WIDTH];
      assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];
    end else begin : g_behav
      assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      assign ovf = (a[WIDTH-1] ~^ b[WIDTH-1]) & (sum[WIDTH-1] ^ a[WIDTH-1]);
    end
  endgenerate
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       sel,
  input  logic             slt_en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_eff,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (res_sel_e'(sel))
      RES_AND:  y = a & b_eff;
      RES_OR:   y = a | b_eff;
      RES_SUM:  y = sum;
      RES_SIGN: y = slt_en ? {{(WIDTH-1){1'b0}}, sum[WIDTH-1]} : '0;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flagged_core.sv
module alu_flagged_core #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       func_sel,
  output logic [WIDTH-1:0] y_out,
  output logic             zero_flag,
  output logic             carry_flag,
  output logic             ovf_flag
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] y_next;
  logic             cout;
  logic             ovf_raw;
  logic             arith;

  alu_b_cond #(.WIDTH(WIDTH)) u_bcond (
    .b_in   (b_in),
    .invert (func_sel[2]),
    .b_eff  (b_eff)
  );

  alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .a    (a_in),
    .b    (b_eff),
    .cin  (func_sel[2]),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf_raw)
  );

  alu_out_mux #(.WIDTH(WIDTH)) u_mux (
    .sel    (func_sel[1:0]),
    .slt_en (func_sel[2]),
    .a      (a_in),
    .b_eff  (b_eff),
    .sum    (sum),
    .y      (y_next)
  );

  assign arith = (func_sel[1:0] == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out      <= '0;
      zero_flag  <= 1'b1;
      carry_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      y_out      <= y_next;
      zero_flag  <= ~|y_next;
      carry_flag <= arith & cout;
      ovf_flag   <= arith & ovf_raw;
    end
  end
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [2:0]       func_sel,
  input logic [WIDTH-1:0] y_out,
  input logic             zero_flag,
  input logic             carry_flag,
  input logic             ovf_flag
);
  // R8
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (y_out == '0));

  // R3
  and_result_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel == 3'b000) |=> (y_out == $past(a_in & b_in)));

  // R4
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel == FN_ADD) |=> (y_out == $past(a_in + b_in)));

  // R5
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel == FN_SUB) |=> (y_out == $past(a_in - b_in)));

  // R6
  less_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel == FN_LESS) |=> (y_out[WIDTH-1:1] == '0));

  // R7
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel == FN_UNUSED) |=> (zero_flag && !carry_flag && !ovf_flag));

  // R9
  carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel != FN_ADD && func_sel != FN_SUB) |=> !carry_flag);

  // R10
  ovf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (func_sel != FN_ADD && func_sel != FN_SUB) |=> !ovf_flag);
endmodule

bind alu_flagged_core alu_flag_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .a_in       (a_in),
  .b_in       (b_in),
  .func_sel   (func_sel),
  .y_out      (y_out),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/alu_flagged_core_tb.sv
module alu_flagged_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [2:0]   func_sel = '0;
  logic [W-1:0] y_out;
  logic         zero_flag, carry_flag, ovf_flag;

  int checks = 0;
  int errors = 0;

  logic [W+2:0] exp_q[$];
  logic [2:0]   fn_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flagged_core #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .func_sel(func_sel),
    .y_out(y_out), .zero_flag(zero_flag), .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  function automatic string code_tag(input logic [2:0] f);
    case (f)
      3'b010:  return "R4";
      3'b110:  return "R5";
      3'b111:  return "R6";
      3'b011:  return "R7";
      default: return "R3";
    endcase
  endfunction

  // Behavioural model: {y, zero, carry, ovf}
  function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] f);
    logic [W-1:0] y;
    logic [W:0]   wide;
    logic         c, v;
    c = 1'b0;
    v = 1'b0;
    case (f)
      3'b000: y = a & b;
      3'b001: y = a | b;
      3'b100: y = a & ~b;
      3'b101: y = a | ~b;
      3'b010: begin
        wide = {1'b0, a} + {1'b0, b};
        y = wide[W-1:0];
        c = wide[W];
        v = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      3'b110: begin
        wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
        y = wide[W-1:0];
        c = wide[W];
        v = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      end
      3'b111: begin
        y = a - b;
        y = y[W-1] ? 32'd1 : 32'd0;
      end
      default: y = '0;
    endcase
    return {y, (y == '0), c, v};
  endfunction

  task automatic check_out(input logic [W+2:0] exp, input string tag);
    checks++;
    if (y_out !== exp[W+2:3]) begin
      errors++;
      $display("FAIL %s result: got %h expected %h", tag, y_out, exp[W+2:3]);
    end
    checks++;
    if (zero_flag !== exp[2]) begin
      errors++;
      $display("FAIL R8 (%s) zero: got %b expected %b", tag, zero_flag, exp[2]);
    end
    checks++;
    if (carry_flag !== exp[1]) begin
      errors++;
      $display("FAIL R9 (%s) carry: got %b expected %b", tag, carry_flag, exp[1]);
    end
    checks++;
    if (ovf_flag !== exp[0]) begin
      errors++;
      $display("FAIL R10 (%s) ovf: got %b expected %b", tag, ovf_flag, exp[0]);
    end
  endtask

  // One cycle: compare what the previous edge produced (R2), then drive new inputs
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [2:0] pf;
      pf = fn_q.pop_front();
      check_out(exp_q.pop_front(), {"R2/", code_tag(pf)});
    end
    a_in = a;
    b_in = b;
    func_sel = f;
    exp_q.push_back(model(a, b, f));
    fn_q.push_back(f);
  endtask

  task automatic reset_check(input string why);
    @(negedge clk);
    exp_q.delete();
    fn_q.delete();
    rst = 1'b1;
    a_in = 32'hDEAD_BEEF;
    b_in = 32'h1234_5678;
    func_sel = 3'b010;
    @(negedge clk);
    check_out({32'h0, 1'b1, 1'b0, 1'b0}, {"R1 ", why});
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_out({32'h0, 1'b1, 1'b0, 1'b0}, "R1 power-up");
    rst = 1'b0;

    // Directed corner cases
    step(32'd25, 32'd32, 3'b111);                  // R6 -> 1
    step(32'h8000_0000, 32'd1, 3'b111);            // R6 raw sign -> 0
    step(32'd32, 32'd25, 3'b111);                  // R6 -> 0
    step(32'h7FFF_FFFF, 32'd1, 3'b010);            // R10 overflow
    step(32'hFFFF_FFFF, 32'd1, 3'b010);            // R9 carry, R8 zero
    step(32'h8000_0000, 32'h8000_0000, 3'b010);    // carry and overflow
    step(32'h0, 32'h0, 3'b110);                    // R5 carry set, zero
    step(32'h1234_5678, 32'h1234_5678, 3'b110);    // equal operands
    step(32'h8000_0000, 32'd1, 3'b110);            // R10 sub overflow
    step(32'd3, 32'd5, 3'b110);                    // borrow
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);    // R7
    step(32'h0000_0DC0, 32'h0000_3C00, 3'b000);
    step(32'h0000_0DC0, 32'h0000_3C00, 3'b001);
    step(32'h0F0F_0F0F, 32'hFFFF_FFFF, 3'b100);    // AND NOT -> 0
    step(32'h0, 32'hFFFF_FFFF, 3'b101);            // OR NOT -> 0
    step(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b101);

    for (int i = 0; i < 1500; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      step(ra, rb, 3'($urandom_range(0, 7)));
    end

    reset_check("mid-run");
    for (int i = 0; i < 200; i++) begin
      step($urandom(), $urandom(), 3'($urandom_range(0, 7)));
    end
    step(32'h0, 32'h0, 3'b000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule